// File: doc/BRIEF.md
# Shared Image Buffer Switch Matrix

Four working buffers, called E, F, G and H, are shared among three initiator ports: a DMA port, a filter I/O port and a lens-correction output port. Each buffer holds 1024 words of 32 bits. A configuration word gives each buffer one owning port. A read or write from a port that does not own the addressed buffer returns zero, leaves memory unchanged and pulses that port's error flag. Because a buffer has only one owner, two ports never compete for it, and no arbitration is needed.

Each port addresses the buffers through 1024-word windows. A per-port offset code sets which buffer appears in which window. The lens port has four windows and the filter port has two; on both, the view is a rotation of E, F, G, H. The DMA port has eight windows. For codes 0 to 4, the unrotated set starts at a window equal to the code. For codes 5 to 7, a rotated set occupies the upper four windows. Every access is one word wide and takes one cycle. Read data comes back on the following clock.

New configuration is written into a shadow copy. The shadow becomes active only in a cycle with no request on any port and no read completing. This keeps in-flight traffic on a single mapping.

Top module: `ibuf_switch`

## Requirements
- R1: After reset, all four buffers are owned by the DMA port and all three offset codes are 0. All read-data outputs and error flags are 0 until a request completes.
- R2: On the lens port, the address is {window[1:0], word[9:0]}. With offset code k, window j maps to buffer (k + j) mod 4, where buffer 0 = E, 1 = F, 2 = G and 3 = H.
- R3: On the filter port, the address is {window[0], word[9:0]}. With offset code k, window 0 maps to buffer k and window 1 maps to buffer (k + 1) mod 4.
- R4: On the DMA port, the address is {window[2:0], word[9:0]}. For code c from 0 to 4, windows c to c+3 map to E, F, G, H in that order. Every other window is unmapped.
- R5: For DMA codes 5, 6 and 7, windows 4 to 7 map to a rotation of the buffers starting at F, G or H respectively. Windows 0 to 3 are unmapped.
- R6: An access to an unmapped window, or to a buffer not owned by the requesting port, behaves as follows. A write is dropped, a read returns 0, and the port's error flag is high for exactly one cycle, the cycle after the request. The owner code is 2 bits per buffer, with buffer b at bits [2b+1:2b]: 0 = DMA, 1 = filter, 2 = lens, 3 = no port.
- R7: Read data appears on the clock after a valid read request and lasts one cycle. In any other cycle, the read-data outputs are 0.
- R8: Storage is little-endian. Byte-enable bit i writes data bits [8i+7:8i], and a byte whose enable is clear keeps its old value.
- R9: A configuration write is held in a shadow copy. The shadow becomes active at the first clock edge at which no port has a request and no read was requested in the previous cycle. Until then, the old mapping applies.
- R10: Buffer contents survive a change of ownership or offset. Data written through one port can be read through another port after reassignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Loads the shadow configuration |
| cfgOwner | input | 8 | Owner code per buffer, 2 bits each |
| cfgDmaOfs | input | 3 | DMA port offset code |
| cfgFltOfs | input | 2 | Filter port offset code |
| cfgLcoOfs | input | 2 | Lens port offset code |
| dmaReq | input | 1 | DMA request valid |
| dmaWe | input | 1 | DMA write (1) or read (0) |
| dmaBe | input | 4 | DMA byte enables |
| dmaAddr | input | 13 | DMA word address |
| dmaWdata | input | 32 | DMA write data |
| dmaRdata | output | 32 | DMA read data |
| dmaErr | output | 1 | DMA access error pulse |
| fltReq | input | 1 | Filter request valid |
| fltWe | input | 1 | Filter write (1) or read (0) |
| fltBe | input | 4 | Filter byte enables |
| fltAddr | input | 11 | Filter word address |
| fltWdata | input | 32 | Filter write data |
| fltRdata | output | 32 | Filter read data |
| fltErr | output | 1 | Filter access error pulse |
| lcoReq | input | 1 | Lens request valid |
| lcoWe | input | 1 | Lens write (1) or read (0) |
| lcoBe | input | 4 | Lens byte enables |
| lcoAddr | input | 12 | Lens word address |
| lcoWdata | input | 32 | Lens write data |
| lcoRdata | output | 32 | Lens read data |
| lcoErr | output | 1 | Lens access error pulse |

## Verification
The assertions assume that each request lasts one cycle and that inputs settle well away from the clock edge. They also assume that the configuration inputs matter only while `cfgWe` is high. The bench drives every input on the falling edge and releases each request one cycle after raising it. Any configuration change is followed by two idle cycles before the next access. The one exception is the R9 test, which deliberately holds a request across a configuration write so that the frozen mapping can be seen at the read-data port.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int WORD_W    = 32;
  localparam int BUF_WORDS = 1024;
  localparam int NBUF      = 4;
  localparam int NPORT     = 3;
  localparam int WADDR_W   = $clog2(BUF_WORDS);
  localparam int BE_W      = WORD_W / 8;
  localparam int BSEL_W    = $clog2(NBUF);

  typedef enum logic [1:0] {
    PORT_DMA  = 2'd0,
    PORT_FLT  = 2'd1,
    PORT_LCO  = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef struct packed {
    logic [NBUF*2-1:0] owner;
    logic [2:0]        dmaOfs;
    logic [1:0]        fltOfs;
    logic [1:0]        lcoOfs;
  } cfg_t;

  typedef struct packed {
    logic               en;
    logic               we;
    logic [BE_W-1:0]    be;
    port_e              src;
    logic [WADDR_W-1:0] addr;
  } bufStrobe_t;

  typedef struct packed {
    logic              rdOk;
    logic              err;
    logic [BSEL_W-1:0] bufSel;
  } portResp_t;
endpackage

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl
  import ibuf_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                cfgWe,
  input  cfg_t                                cfgIn,
  input  logic [NPORT-1:0]                    req,
  input  logic [NPORT-1:0]                    we,
  input  logic [NPORT-1:0][BE_W-1:0]          be,
  input  logic [NPORT-1:0][2:0]               win,
  input  logic [NPORT-1:0][WADDR_W-1:0]       word,
  output bufStrobe_t [NBUF-1:0]               strb,
  output portResp_t  [NPORT-1:0]              resp,
  output cfg_t                                actCfg
);
  cfg_t shadowCfg;
  logic pending;
  logic rdPrev;
  logic busy;

  logic [NPORT-1:0]             hit;
  logic [NPORT-1:0]             ok;
  logic [NPORT-1:0][BSEL_W-1:0] tgt;
  logic [NPORT-1:0][2:0]        code;

  // window-to-buffer decode; returns {hit, buffer index}
  function automatic logic [2:0] mapWin(input logic [1:0] p, input logic [2:0] c,
                                        input logic [2:0] w);
    logic       h;
    logic [1:0] b;
    h = 1'b1;
    b = c[1:0] + w[1:0];
    if (p == PORT_DMA) begin
      if (c <= 3'd4) begin
        h = ({1'b0, w} >= {1'b0, c}) && ({1'b0, w} < ({1'b0, c} + 4'd4));
        b = w[1:0] - c[1:0];
      end else begin
        h = w[2];
        b = c[1:0] + w[1:0];
      end
    end else if (p == PORT_FLT) begin
      b = c[1:0] + {1'b0, w[0]};
    end
    return {h, b};
  endfunction

  always_comb begin
    code[0] = actCfg.dmaOfs;
    code[1] = {1'b0, actCfg.fltOfs};
    code[2] = {1'b0, actCfg.lcoOfs};
    for (int p = 0; p < NPORT; p++) begin
      {hit[p], tgt[p]} = mapWin(2'(p), code[p], win[p]);
      ok[p] = req[p] && hit[p] && (actCfg.owner[2*tgt[p] +: 2] == 2'(p));
    end
  end

  always_comb begin
    for (int b = 0; b < NBUF; b++) begin
      strb[b] = '0;
      strb[b].src = PORT_NONE;
      for (int p = 0; p < NPORT; p++) begin
        if (ok[p] && (tgt[p] == BSEL_W'(b))) begin
          strb[b].en   = 1'b1;
          strb[b].we   = we[p];
          strb[b].be   = be[p];
          strb[b].src  = port_e'(2'(p));
          strb[b].addr = word[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resp <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        resp[p].rdOk   <= ok[p] && !we[p];
        resp[p].err    <= req[p] && !ok[p];
        resp[p].bufSel <= tgt[p];
      end
    end
  end

  assign busy = (|req) || rdPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actCfg    <= '0;
      shadowCfg <= '0;
      pending   <= 1'b0;
      rdPrev    <= 1'b0;
    end else begin
      rdPrev <= |(req & ~we);
      if (cfgWe) begin
        shadowCfg <= cfgIn;
        pending   <= 1'b1;
      end else if (pending && !busy) begin
        actCfg  <= shadowCfg;
        pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ibuf_datapath.sv
module ibuf_datapath
  import ibuf_pkg::*;
(
  input  logic                          clk,
  input  bufStrobe_t [NBUF-1:0]         strb,
  input  portResp_t  [NPORT-1:0]        resp,
  input  logic [NPORT-1:0][WORD_W-1:0]  wdata,
  output logic [NPORT-1:0][WORD_W-1:0]  rdata
);
  logic [WORD_W-1:0] rdAll [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic [WORD_W-1:0] mem [BUF_WORDS];
    logic [WORD_W-1:0] rdReg;
    logic [WORD_W-1:0] wd;

    always_comb begin
      case (strb[b].src)
        PORT_FLT: wd = wdata[1];
        PORT_LCO: wd = wdata[2];
        default:  wd = wdata[0];
      endcase
    end

    always_ff @(posedge clk) begin
      if (strb[b].en) begin
        if (strb[b].we) begin
          for (int i = 0; i < BE_W; i++) begin
            if (strb[b].be[i]) mem[strb[b].addr][8*i +: 8] <= wd[8*i +: 8];
          end
        end else begin
          rdReg <= mem[strb[b].addr];
        end
      end
    end

    assign rdAll[b] = rdReg;
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rdata[p] = resp[p].rdOk ? rdAll[resp[p].bufSel] : '0;
    end
  end
endmodule

// File: rtl/ibuf_switch.sv
module ibuf_switch
  import ibuf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [NBUF*2-1:0]    cfgOwner,
  input  logic [2:0]           cfgDmaOfs,
  input  logic [1:0]           cfgFltOfs,
  input  logic [1:0]           cfgLcoOfs,
  input  logic                 dmaReq,
  input  logic                 dmaWe,
  input  logic [BE_W-1:0]      dmaBe,
  input  logic [WADDR_W+2:0]   dmaAddr,
  input  logic [WORD_W-1:0]    dmaWdata,
  output logic [WORD_W-1:0]    dmaRdata,
  output logic                 dmaErr,
  input  logic                 fltReq,
  input  logic                 fltWe,
  input  logic [BE_W-1:0]      fltBe,
  input  logic [WADDR_W:0]     fltAddr,
  input  logic [WORD_W-1:0]    fltWdata,
  output logic [WORD_W-1:0]    fltRdata,
  output logic                 fltErr,
  input  logic                 lcoReq,
  input  logic                 lcoWe,
  input  logic [BE_W-1:0]      lcoBe,
  input  logic [WADDR_W+1:0]   lcoAddr,
  input  logic [WORD_W-1:0]    lcoWdata,
  output logic [WORD_W-1:0]    lcoRdata,
  output logic                 lcoErr
);
  cfg_t                          cfgIn;
  cfg_t                          actCfg;
  logic [NPORT-1:0]              reqV;
  logic [NPORT-1:0]              weV;
  logic [NPORT-1:0][BE_W-1:0]    beV;
  logic [NPORT-1:0][2:0]         winV;
  logic [NPORT-1:0][WADDR_W-1:0] wordV;
  logic [NPORT-1:0][WORD_W-1:0]  wdV;
  logic [NPORT-1:0][WORD_W-1:0]  rdV;
  bufStrobe_t [NBUF-1:0]         strb;
  portResp_t  [NPORT-1:0]        resp;

  assign cfgIn = '{owner: cfgOwner, dmaOfs: cfgDmaOfs, fltOfs: cfgFltOfs, lcoOfs: cfgLcoOfs};

  assign reqV  = {lcoReq, fltReq, dmaReq};
  assign weV   = {lcoWe, fltWe, dmaWe};
  assign beV   = {lcoBe, fltBe, dmaBe};
  assign wdV   = {lcoWdata, fltWdata, dmaWdata};
  assign winV[0]  = dmaAddr[WADDR_W+2:WADDR_W];
  assign winV[1]  = {2'b00, fltAddr[WADDR_W]};
  assign winV[2]  = {1'b0, lcoAddr[WADDR_W+1:WADDR_W]};
  assign wordV[0] = dmaAddr[WADDR_W-1:0];
  assign wordV[1] = fltAddr[WADDR_W-1:0];
  assign wordV[2] = lcoAddr[WADDR_W-1:0];

  ibuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIn(cfgIn),
    .req(reqV), .we(weV), .be(beV), .win(winV), .word(wordV),
    .strb(strb), .resp(resp), .actCfg(actCfg)
  );

  ibuf_datapath u_dp (
    .clk(clk), .strb(strb), .resp(resp), .wdata(wdV), .rdata(rdV)
  );

  assign dmaRdata = rdV[0];
  assign fltRdata = rdV[1];
  assign lcoRdata = rdV[2];
  assign dmaErr   = resp[0].err;
  assign fltErr   = resp[1].err;
  assign lcoErr   = resp[2].err;
endmodule

// File: rtl/ibuf_checker.sv
module ibuf_checker
  import ibuf_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dmaReq,
  input logic              fltReq,
  input logic              lcoReq,
  input logic [WORD_W-1:0] dmaRdata,
  input logic [WORD_W-1:0] fltRdata,
  input logic [WORD_W-1:0] lcoRdata,
  input logic              dmaErr,
  input logic              fltErr,
  input logic              lcoErr,
  input cfg_t              actCfg
);
  // R6: a rejected access never carries data
  a_r6_err_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr || fltErr || lcoErr) |->
      ((!dmaErr || dmaRdata == '0) && (!fltErr || fltRdata == '0) && (!lcoErr || lcoRdata == '0)));

  // R6: an error pulse follows a request on the same port
  a_r6_err_after_req: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr |-> $past(dmaReq)) and (fltErr |-> $past(fltReq)) and (lcoErr |-> $past(lcoReq)));

  // R7: a port idle in one cycle shows no data and no error in the next
  a_r7_dma_idle: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReq |=> (dmaRdata == '0 && !dmaErr));
  a_r7_flt_idle: assert property (@(posedge clk) disable iff (!rstN)
    !fltReq |=> (fltRdata == '0 && !fltErr));
  a_r7_lco_idle: assert property (@(posedge clk) disable iff (!rstN)
    !lcoReq |=> (lcoRdata == '0 && !lcoErr));

  // R9: the active mapping cannot change across a cycle with a request
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq || fltReq || lcoReq) |=> $stable(actCfg));
endmodule

bind ibuf_switch ibuf_checker u_chk (
  .clk(clk), .rstN(rstN),
  .dmaReq(dmaReq), .fltReq(fltReq), .lcoReq(lcoReq),
  .dmaRdata(dmaRdata), .fltRdata(fltRdata), .lcoRdata(lcoRdata),
  .dmaErr(dmaErr), .fltErr(fltErr), .lcoErr(lcoErr),
  .actCfg(actCfg)
);

// File: tb/ibuf_switch_tb.sv
`timescale 1ns/1ps
module ibuf_switch_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [7:0] cfgOwner = '0;
  logic [2:0] cfgDmaOfs = '0;
  logic [1:0] cfgFltOfs = '0, cfgLcoOfs = '0;
  logic dmaReq = 0, dmaWe = 0, fltReq = 0, fltWe = 0, lcoReq = 0, lcoWe = 0;
  logic [3:0] dmaBe = '0, fltBe = '0, lcoBe = '0;
  logic [12:0] dmaAddr = '0;
  logic [10:0] fltAddr = '0;
  logic [11:0] lcoAddr = '0;
  logic [31:0] dmaWdata = '0, fltWdata = '0, lcoWdata = '0;
  logic [31:0] dmaRdata, fltRdata, lcoRdata;
  logic dmaErr, fltErr, lcoErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ibuf_switch u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOwner(cfgOwner),
    .cfgDmaOfs(cfgDmaOfs), .cfgFltOfs(cfgFltOfs), .cfgLcoOfs(cfgLcoOfs),
    .dmaReq(dmaReq), .dmaWe(dmaWe), .dmaBe(dmaBe), .dmaAddr(dmaAddr),
    .dmaWdata(dmaWdata), .dmaRdata(dmaRdata), .dmaErr(dmaErr),
    .fltReq(fltReq), .fltWe(fltWe), .fltBe(fltBe), .fltAddr(fltAddr),
    .fltWdata(fltWdata), .fltRdata(fltRdata), .fltErr(fltErr),
    .lcoReq(lcoReq), .lcoWe(lcoWe), .lcoBe(lcoBe), .lcoAddr(lcoAddr),
    .lcoWdata(lcoWdata), .lcoRdata(lcoRdata), .lcoErr(lcoErr)
  );

  // {port[1:0], we, addr[12:0], wdata[31:0], expData[31:0], expErr}
  localparam int NVEC = 13;
  localparam logic [80:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 13'h0005, 32'hE0000005, 32'h0, 1'b0},
    {2'd0, 1'b1, 13'h0407, 32'hF0000007, 32'h0, 1'b0},
    {2'd0, 1'b1, 13'h0A00, 32'h60000200, 32'h0, 1'b0},
    {2'd0, 1'b1, 13'h0FFF, 32'h40000FFF, 32'h0, 1'b0},
    {2'd0, 1'b0, 13'h0005, 32'h0, 32'hE0000005, 1'b0},
    {2'd0, 1'b0, 13'h0407, 32'h0, 32'hF0000007, 1'b0},
    {2'd0, 1'b0, 13'h0A00, 32'h0, 32'h60000200, 1'b0},
    {2'd0, 1'b0, 13'h0FFF, 32'h0, 32'h40000FFF, 1'b0},
    {2'd0, 1'b0, 13'h1000, 32'h0, 32'h0, 1'b1},
    {2'd1, 1'b1, 13'h0005, 32'hDEADBEEF, 32'h0, 1'b1},
    {2'd0, 1'b0, 13'h0005, 32'h0, 32'hE0000005, 1'b0},
    {2'd2, 1'b0, 13'h0C00, 32'h0, 32'h0, 1'b1},
    {2'd0, 1'b0, 13'h1C00, 32'h0, 32'h0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic acc(input int p, input logic we, input logic [3:0] be, input logic [12:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    case (p)
      0: begin dmaReq = 1; dmaWe = we; dmaBe = be; dmaAddr = a; dmaWdata = d; end
      1: begin fltReq = 1; fltWe = we; fltBe = be; fltAddr = a[10:0]; fltWdata = d; end
      default: begin lcoReq = 1; lcoWe = we; lcoBe = be; lcoAddr = a[11:0]; lcoWdata = d; end
    endcase
    @(negedge clk);
    dmaReq = 0; fltReq = 0; lcoReq = 0;
    case (p)
      0: begin rd = dmaRdata; er = dmaErr; end
      1: begin rd = fltRdata; er = fltErr; end
      default: begin rd = lcoRdata; er = lcoErr; end
    endcase
  endtask

  task automatic rdChk(input string tag, input int p, input logic [12:0] a,
                       input logic [31:0] expD, input logic expE);
    logic [31:0] rd;
    logic er;
    acc(p, 1'b0, 4'h0, a, 32'h0, rd, er);
    chk({tag, " data"}, rd, expD);
    chk({tag, " err"}, {31'b0, er}, {31'b0, expE});
  endtask

  task automatic setCfg(input logic [7:0] own, input logic [2:0] dOfs,
                        input logic [1:0] fOfs, input logic [1:0] lOfs);
    @(negedge clk);
    cfgWe = 1; cfgOwner = own; cfgDmaOfs = dOfs; cfgFltOfs = fOfs; cfgLcoOfs = lOfs;
    @(negedge clk);
    cfgWe = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: quiet outputs after reset
    chk("R1 dmaRdata", dmaRdata, 32'h0);
    chk("R1 errs", {29'b0, dmaErr, fltErr, lcoErr}, 32'h0);
    chk("R1 rdata others", fltRdata | lcoRdata, 32'h0);

    // table under the reset mapping (R1, R4, R6, R7)
    for (int i = 0; i < NVEC; i++) begin
      logic [80:0] v;
      v = VEC[i];
      acc(int'(v[80:79]), v[78], 4'hF, v[77:65], v[64:33], rd, er);
      chk($sformatf("R1/R6/R7 vec%0d data", i), rd, v[32:1]);
      chk($sformatf("R6 vec%0d err", i), {31'b0, er}, {31'b0, v[0]});
    end

    // R7: data lasts one cycle
    acc(0, 1'b0, 4'h0, 13'h0005, 32'h0, rd, er);
    chk("R7 read", rd, 32'hE0000005);
    @(negedge clk);
    chk("R7 next cycle zero", dmaRdata, 32'h0);

    // R8: byte lanes
    acc(0, 1'b1, 4'b0010, 13'h0005, 32'hFFFFFFFF, rd, er);
    rdChk("R8 lane1", 0, 13'h0005, 32'hE000FF05, 1'b0);
    acc(0, 1'b1, 4'b1000, 13'h0005, 32'h12345678, rd, er);
    rdChk("R8 lane3", 0, 13'h0005, 32'h1200FF05, 1'b0);

    // R9: configuration held back while a request stays active
    @(negedge clk);
    dmaReq = 1; dmaWe = 0; dmaAddr = 13'h0005;
    @(negedge clk);
    cfgWe = 1; cfgOwner = 8'h00; cfgDmaOfs = 3'd1; cfgFltOfs = 0; cfgLcoOfs = 0;
    chk("R9 before cfg", dmaRdata, 32'h1200FF05);
    @(negedge clk);
    cfgWe = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R9 held mapping", dmaRdata, 32'h1200FF05);
      @(negedge clk);
    end
    dmaReq = 0;
    chk("R9 last held read", dmaRdata, 32'h1200FF05);
    @(negedge clk);
    @(negedge clk);
    rdChk("R9 R4 ofs1 win0 unmapped", 0, 13'h0005, 32'h0, 1'b1);
    rdChk("R4 ofs1 win1 E", 0, 13'h0405, 32'h1200FF05, 1'b0);
    rdChk("R4 ofs1 win4 H", 0, 13'h13FF, 32'h40000FFF, 1'b0);

    // R4, R5: DMA codes
    setCfg(8'h00, 3'd4, 2'd0, 2'd0);
    rdChk("R4 ofs4 win4 E", 0, 13'h1005, 32'h1200FF05, 1'b0);
    rdChk("R4 ofs4 win7 H", 0, 13'h1FFF, 32'h40000FFF, 1'b0);
    rdChk("R4 ofs4 win3 unmapped", 0, 13'h0C00, 32'h0, 1'b1);
    setCfg(8'h00, 3'd6, 2'd0, 2'd0);
    rdChk("R5 ofs6 win4 G", 0, 13'h1200, 32'h60000200, 1'b0);
    rdChk("R5 ofs6 win7 F", 0, 13'h1C07, 32'hF0000007, 1'b0);
    rdChk("R5 ofs6 win3 unmapped", 0, 13'h0C00, 32'h0, 1'b1);
    setCfg(8'h00, 3'd5, 2'd0, 2'd0);
    rdChk("R5 ofs5 win7 E", 0, 13'h1C05, 32'h1200FF05, 1'b0);
    rdChk("R5 ofs5 win5 G", 0, 13'h1600, 32'h60000200, 1'b0);

    // R2, R10: lens port owns everything
    setCfg(8'hAA, 3'd4, 2'd0, 2'd3);
    rdChk("R2 R10 k3 win0 H", 2, 13'h03FF, 32'h40000FFF, 1'b0);
    rdChk("R2 k3 win1 E", 2, 13'h0405, 32'h1200FF05, 1'b0);
    rdChk("R6 dma not owner", 0, 13'h1005, 32'h0, 1'b1);
    setCfg(8'hAA, 3'd4, 2'd0, 2'd1);
    rdChk("R2 k1 win2 H", 2, 13'h0BFF, 32'h40000FFF, 1'b0);
    rdChk("R2 k1 win3 E", 2, 13'h0C05, 32'h1200FF05, 1'b0);

    // R3: filter owns G and H
    setCfg(8'h50, 3'd0, 2'd2, 2'd0);
    rdChk("R3 k2 win0 G", 1, 13'h0200, 32'h60000200, 1'b0);
    rdChk("R3 k2 win1 H", 1, 13'h07FF, 32'h40000FFF, 1'b0);
    setCfg(8'h50, 3'd0, 2'd3, 2'd0);
    rdChk("R3 k3 win0 H", 1, 13'h03FF, 32'h40000FFF, 1'b0);
    rdChk("R3 R6 k3 win1 E not owned", 1, 13'h0405, 32'h0, 1'b1);

    // R6: unassigned buffers
    setCfg(8'hFF, 3'd0, 2'd0, 2'd0);
    rdChk("R6 no owner", 0, 13'h0005, 32'h0, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule